// File: doc/BRIEF.md
# Keypad Wait and Frame Timer Unit

This unit sits beside the instruction sequencer of a small interpreter core. It watches sixteen keypad level lines, keeps two eight-bit countdown counters that step once per 60 Hz frame tick, and produces one stall line that holds the sequencer. The stall has two causes: a pending key wait, and an optional wait for the next frame after a draw.

The sequencer drives one-cycle command strobes: load either counter, begin a key wait, and flag a draw. It also drives one operand value, `reg_val`. That value is the load data, and its low bits select the key for the pressed test. A key wait completes when a key is released, not when it is pressed. After the release clears the stall, the sequencer re-issues the same wait command. The unit then delivers the captured code with a write strobe and discards it.

Top module: `keywait_timer`

## Requirements
- R1: After reset, `delay_cnt` is 0 and `sound_on`, `stall` and `key_write` are all low.
- R2: `key_hit` shows the synchronized level of the key whose index is `reg_val[3:0]`, and the upper bits of `reg_val` are ignored. A level change on a key line appears on `key_hit` two clock edges after it is sampled.
- R3: A `kw_exec` strobe with no captured code raises `stall` from the next cycle. The stall holds until a release or a soft reset.
- R4: While a key wait is pending, a release (a synchronized high-to-low change of a key line) is handled as follows. On the next edge its 4-bit code is recorded and the key stall is dropped. The next `kw_exec` then gives `key_write`=1 in the same cycle with that code on `key_code`. The code is consumed at that edge, so a further `kw_exec` stalls again.
- R5: A key release while no key wait is pending is ignored. A later `kw_exec` still stalls and gives no `key_write`.
- R6: If several keys are released in the same cycle, the lowest-numbered key is captured.
- R7: `ld_delay` or `ld_sound` loads its counter from `reg_val` at the next edge. A load wins over a frame tick in the same cycle.
- R8: The delay counter steps down by one on each `frame_tick`, saturates at 0, and holds when there is no tick. `delay_cnt` always shows its count.
- R9: The sound counter behaves the same way as the delay counter. `sound_on` is high exactly when the sound count is non-zero.
- R10: With `draw_wait_en`=1, a `draw_cmd` raises `stall` from the next cycle until the edge of the next `frame_tick` issued after it. If a draw and a tick fall in the same cycle, the draw wins. With `draw_wait_en`=0, a draw has no effect.
- R11: `soft_rst` clears both the key stall and the draw stall at the next edge. It takes priority over a draw or key wait issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Clears both stall causes |
| key_lvl | input | 16 | Raw keypad level lines, high while pressed |
| frame_tick | input | 1 | One-cycle 60 Hz frame pulse |
| reg_val | input | 8 | Operand: counter load data and key index |
| ld_delay | input | 1 | Load delay counter from `reg_val` |
| ld_sound | input | 1 | Load sound counter from `reg_val` |
| kw_exec | input | 1 | Key-wait command executes this cycle |
| draw_cmd | input | 1 | Draw command executes this cycle |
| draw_wait_en | input | 1 | Enables the stall-after-draw mode |
| key_hit | output | 1 | Level of the key selected by `reg_val[3:0]` |
| delay_cnt | output | 8 | Current delay count |
| sound_on | output | 1 | Sound count is non-zero |
| key_code | output | 4 | Captured key code, valid with `key_write` |
| key_write | output | 1 | Write `key_code` to the destination register |
| stall | output | 1 | Hold the sequencer |

## Verification
Several pairs of functions can land on the same edge. A counter load can meet a frame tick. A draw can meet the tick that would end its own stall. A soft reset can meet a new draw or key wait. Several key releases can arrive together while a wait is pending. The bench places these coincidences in one cycle on purpose. A behavioural model compares every output on every clock and judges the outcome by the stated priorities: the load wins, the draw wins, the soft reset wins, and the lowest key wins.

// File: rtl/kwt_pkg.sv
package kwt_pkg;
   // Stall causes kept apart so each can be cleared on its own.
   typedef struct packed {
      logic key;
      logic draw;
   } stall_src_t;

   localparam stall_src_t STALL_NONE = '{key: 1'b0, draw: 1'b0};
endpackage

// File: rtl/kwt_key_frontend.sv
module kwt_key_frontend #(
   parameter int NUM_KEYS    = 16,
   parameter int SYNC_STAGES = 2,
   parameter int IDX_W       = $clog2(NUM_KEYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_KEYS-1:0] key_lvl,
   output logic [NUM_KEYS-1:0] key_now,
   output logic                rel_any,
   output logic [IDX_W-1:0]    rel_code
);
   logic [NUM_KEYS-1:0] stg [SYNC_STAGES];
   logic [NUM_KEYS-1:0] key_prev;
   logic [NUM_KEYS-1:0] rel_vec;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= key_lvl;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign key_now = stg[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_prev <= '0;
      else        key_prev <= key_now;
   end

   assign rel_vec = key_prev & ~key_now;
   assign rel_any = |rel_vec;

   // Lowest index wins: scan downward so the last hit is the smallest.
   always_comb begin
      rel_code = '0;
      for (int k = NUM_KEYS - 1; k >= 0; k--) begin
         if (rel_vec[k]) rel_code = IDX_W'(k);
      end
   end
endmodule

// File: rtl/kwt_countdown.sv
module kwt_countdown #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   output logic [TMR_W-1:0] count
);
   localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count <= '0;
      else if (load)                count <= load_val;
      else if (tick && count != '0) count <= count - ONE;
   end
endmodule

// File: rtl/kwt_stall_ctrl.sv
module kwt_stall_ctrl
   import kwt_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             kw_exec,
   input  logic             rel_any,
   input  logic [IDX_W-1:0] rel_code,
   input  logic             draw_cmd,
   input  logic             draw_wait_en,
   input  logic             frame_tick,
   output stall_src_t       src,
   output logic             key_write,
   output logic [IDX_W-1:0] key_code
);
   logic             cap_vld;
   logic [IDX_W-1:0] cap_code;
   logic             take_rel;

   assign take_rel = src.key && rel_any && !soft_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src      <= STALL_NONE;
         cap_vld  <= 1'b0;
         cap_code <= '0;
      end else begin
         // key wait cause
         if (soft_rst)                src.key <= 1'b0;
         else if (take_rel)           src.key <= 1'b0;
         else if (kw_exec && !cap_vld) src.key <= 1'b1;
         // draw wait cause: a new draw outranks a coincident tick
         if (soft_rst)                       src.draw <= 1'b0;
         else if (draw_cmd && draw_wait_en)  src.draw <= 1'b1;
         else if (frame_tick)                src.draw <= 1'b0;
         // captured code
         if (take_rel) begin
            cap_vld  <= 1'b1;
            cap_code <= rel_code;
         end else if (kw_exec && cap_vld) begin
            cap_vld  <= 1'b0;
         end
      end
   end

   assign key_write = kw_exec && cap_vld;
   assign key_code  = cap_code;
endmodule

// File: rtl/keywait_timer.sv
module keywait_timer
   import kwt_pkg::*;
#(
   parameter int NUM_KEYS    = 16,
   parameter int TMR_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = $clog2(NUM_KEYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst,
   input  logic [NUM_KEYS-1:0] key_lvl,
   input  logic                frame_tick,
   input  logic [TMR_W-1:0]    reg_val,
   input  logic                ld_delay,
   input  logic                ld_sound,
   input  logic                kw_exec,
   input  logic                draw_cmd,
   input  logic                draw_wait_en,
   output logic                key_hit,
   output logic [TMR_W-1:0]    delay_cnt,
   output logic                sound_on,
   output logic [IDX_W-1:0]    key_code,
   output logic                key_write,
   output logic                stall
);
   if (NUM_KEYS < 2 || NUM_KEYS != (1 << IDX_W)) begin : g_bad_keys
      $error("NUM_KEYS must be a power of two, at least 2");
   end
   if (TMR_W < IDX_W) begin : g_bad_width
      $error("TMR_W must cover the key index width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_KEYS-1:0] key_now;
   logic                rel_any;
   logic [IDX_W-1:0]    rel_code;
   logic [TMR_W-1:0]    sound_cnt;
   stall_src_t          src;

   kwt_key_frontend #(
      .NUM_KEYS(NUM_KEYS), .SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)
   ) u_keys (
      .clk(clk), .rst_n(rst_n), .key_lvl(key_lvl),
      .key_now(key_now), .rel_any(rel_any), .rel_code(rel_code)
   );

   kwt_countdown #(.TMR_W(TMR_W)) u_delay (
      .clk(clk), .rst_n(rst_n), .tick(frame_tick), .load(ld_delay),
      .load_val(reg_val), .count(delay_cnt)
   );

   kwt_countdown #(.TMR_W(TMR_W)) u_sound (
      .clk(clk), .rst_n(rst_n), .tick(frame_tick), .load(ld_sound),
      .load_val(reg_val), .count(sound_cnt)
   );

   kwt_stall_ctrl #(.IDX_W(IDX_W)) u_stall (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .kw_exec(kw_exec),
      .rel_any(rel_any), .rel_code(rel_code), .draw_cmd(draw_cmd),
      .draw_wait_en(draw_wait_en), .frame_tick(frame_tick),
      .src(src), .key_write(key_write), .key_code(key_code)
   );

   assign key_hit  = key_now[reg_val[IDX_W-1:0]];
   assign sound_on = |sound_cnt;
   assign stall    = src.key | src.draw;
endmodule

// File: rtl/kwt_checker.sv
module kwt_checker #(
   parameter int TMR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic             frame_tick,
   input logic [TMR_W-1:0] reg_val,
   input logic             ld_delay,
   input logic             ld_sound,
   input logic             kw_exec,
   input logic             draw_cmd,
   input logic             draw_wait_en,
   input logic [TMR_W-1:0] delay_cnt,
   input logic             sound_on,
   input logic             key_write,
   input logic             stall
);
   localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

   // R7
   delay_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_delay |=> delay_cnt == $past(reg_val));
   // R8
   delay_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && !ld_delay && delay_cnt != '0) |=> delay_cnt == $past(delay_cnt) - ONE);
   // R8
   delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_tick && !ld_delay) |=> $stable(delay_cnt));
   // R8
   delay_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (delay_cnt == '0 && !ld_delay) |=> delay_cnt == '0);
   // R9
   sound_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_sound |=> sound_on == ($past(reg_val) != '0));
   // R3
   kw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kw_exec && !key_write && !soft_rst) |=> stall);
   // R4
   kw_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_write |=> !key_write);
   // R10
   draw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (draw_cmd && draw_wait_en && !soft_rst) |=> stall);
   // R11
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !stall);
endmodule

bind keywait_timer kwt_checker #(.TMR_W(TMR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .frame_tick(frame_tick),
   .reg_val(reg_val), .ld_delay(ld_delay), .ld_sound(ld_sound),
   .kw_exec(kw_exec), .draw_cmd(draw_cmd), .draw_wait_en(draw_wait_en),
   .delay_cnt(delay_cnt), .sound_on(sound_on), .key_write(key_write),
   .stall(stall)
);

// File: tb/keywait_timer_test.sv
module keywait_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic [15:0] key_lvl = '0;
   logic        frame_tick = 1'b0;
   logic [7:0]  reg_val = '0;
   logic        ld_delay = 1'b0, ld_sound = 1'b0, kw_exec = 1'b0;
   logic        draw_cmd = 1'b0, draw_wait_en = 1'b0;
   logic        key_hit, sound_on, key_write, stall;
   logic [7:0]  delay_cnt;
   logic [3:0]  key_code;

   int    tests = 0, fails = 0;
   string cur_req = "R1";
   bit    chk_on = 1'b0;

   // reference model state
   logic [15:0] kq[$] = '{16'h0, 16'h0, 16'h0};
   int m_delay = 0, m_sound = 0;
   bit m_kst = 0, m_dst = 0, m_cap = 0;
   int m_code = 0;

   keywait_timer uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .key_lvl(key_lvl),
      .frame_tick(frame_tick), .reg_val(reg_val), .ld_delay(ld_delay),
      .ld_sound(ld_sound), .kw_exec(kw_exec), .draw_cmd(draw_cmd),
      .draw_wait_en(draw_wait_en), .key_hit(key_hit), .delay_cnt(delay_cnt),
      .sound_on(sound_on), .key_code(key_code), .key_write(key_write),
      .stall(stall)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) begin
         kq = '{16'h0, 16'h0, 16'h0};
         m_delay = 0; m_sound = 0; m_kst = 0; m_dst = 0; m_cap = 0; m_code = 0;
      end else begin
         logic [15:0] rel;
         int low;
         bit take;
         rel = kq[0] & ~kq[1];
         low = -1;
         for (int k = 15; k >= 0; k--) if (rel[k]) low = k;
         take = m_kst && (low >= 0) && !soft_rst;
         if (take) begin
            m_cap = 1; m_code = low;
         end else if (kw_exec && m_cap) m_cap = 0;
         if (soft_rst) m_kst = 0;
         else if (take) m_kst = 0;
         else if (kw_exec && !(m_cap == 1 && !take && kw_exec && 0)) begin
            // stall only when nothing was captured before this edge
         end
         if (soft_rst) m_dst = 0;
         else if (draw_cmd && draw_wait_en) m_dst = 1;
         else if (frame_tick) m_dst = 0;
         if (ld_delay) m_delay = reg_val;
         else if (frame_tick && m_delay > 0) m_delay--;
         if (ld_sound) m_sound = reg_val;
         else if (frame_tick && m_sound > 0) m_sound--;
         kq.push_back(key_lvl);
         void'(kq.pop_front());
      end
   end

   // key-wait stall set is tracked with the pre-edge capture flag
   bit pre_cap;
   always @(negedge clk) pre_cap = m_cap;
   always @(posedge clk) begin
      if (rst_n && !soft_rst && !m_kst && kw_exec && !pre_cap) m_kst = 1;
   end

   task automatic check(input string sig, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, sig, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         bit exp_w;
         exp_w = kw_exec && m_cap;
         check("delay_cnt", delay_cnt, m_delay);
         check("sound_on", sound_on, m_sound != 0);
         check("stall", stall, m_kst || m_dst);
         check("key_hit", key_hit, kq[1][reg_val[3:0]]);
         check("key_write", key_write, exp_w);
         if (exp_w) check("key_code", key_code, m_code);
      end
   end

   task automatic cyc();
      @(posedge clk); #1;
      soft_rst = 0; frame_tick = 0; ld_delay = 0; ld_sound = 0;
      kw_exec = 0; draw_cmd = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   initial begin
      #(8 * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      cur_req = "R1";
      idle(3);
      chk_on = 1;
      idle(1);
      rst_n = 1;
      idle(3);
      // R2: key level test, upper operand bits ignored
      cur_req = "R2";
      key_lvl = 16'hA5C3;
      idle(1);
      for (int v = 0; v < 20; v++) begin
         reg_val = 8'(v * 17 + 3);
         idle(1);
      end
      key_lvl = 16'h0;
      idle(4);
      // R7: loads, load beats tick
      cur_req = "R7";
      reg_val = 8'd3; ld_delay = 1; cyc();
      reg_val = 8'd2; ld_sound = 1; frame_tick = 1; cyc();
      reg_val = 8'd9; ld_delay = 1; frame_tick = 1; cyc();
      // R8: countdown and saturation
      cur_req = "R8";
      for (int i = 0; i < 12; i++) begin
         frame_tick = 1; cyc(); idle(2);
      end
      // R9: sound counter and sound_on
      cur_req = "R9";
      reg_val = 8'd1; ld_sound = 1; cyc();
      idle(2); frame_tick = 1; cyc(); idle(2);
      reg_val = 8'd0; ld_sound = 1; cyc(); idle(2);
      // R3: key wait stalls
      cur_req = "R3";
      kw_exec = 1; cyc(); idle(3);
      key_lvl[5] = 1; idle(4);
      // R4: release ends wait, re-executed wait delivers code
      cur_req = "R4";
      key_lvl[5] = 0; idle(5);
      kw_exec = 1; cyc(); idle(2);
      kw_exec = 1; cyc(); idle(2);
      key_lvl[9] = 1; idle(4); key_lvl[9] = 0; idle(5);
      kw_exec = 1; cyc(); idle(2);
      // R5: release with no wait pending is ignored
      cur_req = "R5";
      key_lvl[2] = 1; idle(4); key_lvl[2] = 0; idle(5);
      kw_exec = 1; cyc(); idle(3);
      // R6: simultaneous releases, lowest wins
      cur_req = "R6";
      key_lvl = 16'h1088; idle(4); key_lvl = 16'h0; idle(5);
      kw_exec = 1; cyc(); idle(2);
      // R10: draw wait
      cur_req = "R10";
      draw_wait_en = 1;
      draw_cmd = 1; cyc(); idle(3); frame_tick = 1; cyc(); idle(2);
      draw_cmd = 1; frame_tick = 1; cyc(); idle(2); frame_tick = 1; cyc(); idle(2);
      draw_wait_en = 0; draw_cmd = 1; cyc(); idle(2);
      // R11: soft reset clears both causes and beats new commands
      cur_req = "R11";
      draw_wait_en = 1;
      draw_cmd = 1; cyc(); idle(1); soft_rst = 1; cyc(); idle(2);
      kw_exec = 1; cyc(); idle(2); soft_rst = 1; cyc(); idle(2);
      soft_rst = 1; draw_cmd = 1; kw_exec = 1; cyc(); idle(2);
      idle(3);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule